// File: doc/BRIEF.md
# Delayed-start message banner transmitter

This block feeds a constant text message, one byte at a time, into a buffered serial transmitter. After reset is released it keeps its output quiet for a programmable number of clock cycles. The serial line downstream therefore rests at its idle level long enough for the far-end receiver to synchronise before the first start bit. Once that interval has passed, it hands over the message bytes from the first to the last and then goes quiet.

A pulse on the start input in the quiet state sends the whole message again, from its first byte. The byte stream leaves on a valid/ready interface. A byte is taken on every rising clock edge at which both valid and ready are high. While ready is low, valid and data hold steady, so messages longer than the transmitter's buffer still arrive complete. The downstream ready is simply the inverse of the transmitter's buffer-full flag.

Top module: `msg_banner_tx`

## Requirements
- R1: While reset (active low) is asserted, `txq_valid_o` is 0 and `busy_o` is 1.
- R2: After reset is released, `txq_valid_o` stays 0 for exactly `SETTLE_CYC` rising edges and rises on the edge numbered `SETTLE_CYC`. The value of `txq_ready_i` does not change this.
- R3: The first byte offered in every message is the first character of the message (position 0, the leftmost character of the `MSG_TEXT` literal).
- R4: Each transfer (valid and ready both high at a rising edge) makes the next message position appear at `txq_data_o` on that same edge, one position per transfer.
- R5: While `txq_ready_i` is 0, `txq_valid_o` stays 1 and `txq_data_o` stays unchanged.
- R6: After the transfer of the last character, `txq_valid_o` is 0 and no further byte is offered until a new start.
- R7: A start pulse while idle makes `txq_valid_o` rise on the next edge, carrying position 0, with no settling delay.
- R8: A start pulse while a message is in progress is ignored. The running message completes exactly once and in order.
- R9: Messages of 15, 16 and 17 characters (`MSG_LEN` from 2 to 32) are delivered complete and in order, under any ready pattern.
- R10: `busy_o` is 1 from reset through the edge that takes the last character, and 0 from then until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Resend request, honoured only while idle |
| txq_ready_i | input | 1 | Transmitter can accept a byte (inverse of its full flag) |
| txq_data_o | output | 8 | Current message byte |
| txq_valid_o | output | 1 | Byte offered; a transfer takes place when ready is also high |
| busy_o | output | 1 | Settling or sending in progress |

## Verification
Every result has a fixed due cycle:
- the first valid appears on the `SETTLE_CYC`-th edge after release;
- after a start pulse, valid rises on the very next edge;
- after a transfer, the next byte appears on the same edge;
- `busy_o` drops on the edge that takes the last byte.

The bench drives its inputs just after each falling edge and samples 1 ns later. Each sample therefore shows the state produced by the preceding rising edge. The bench records a transfer when the ready value it has just applied meets a high valid. Three instances, of 15, 16 and 17 characters, run side by side under three ready patterns. Each sampled byte is compared with the bench's own copy of the text at its running count.

// File: rtl/sndr_pkg.sv
package sndr_pkg;
  localparam int MAX_CHARS = 32;

  typedef enum logic [1:0] {
    ST_SETTLE = 2'd0,
    ST_SEND   = 2'd1,
    ST_IDLE   = 2'd2
  } sndr_state_t;
endpackage

// File: rtl/sndr_settle_timer.sv
module sndr_settle_timer #(
  parameter int SETTLE_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic fire_o,
  output logic done_o
);
  localparam int CNT_W = $clog2(SETTLE_CYC + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(SETTLE_CYC - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             done_q;

  assign fire_o = !done_q && (cnt_q == LAST_CNT);
  assign done_o = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      if (cnt_q == LAST_CNT) done_q <= 1'b1;
      else                   cnt_q  <= cnt_q + 1'b1;
    end
  end

  a_r2_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> done_q);
endmodule

// File: rtl/sndr_char_rom.sv
module sndr_char_rom #(
  parameter int MSG_LEN = 16,
  parameter int IDX_W   = 4,
  parameter logic [8*sndr_pkg::MAX_CHARS-1:0] MSG_TEXT = '0
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic [7:0]       ch_o
);
  localparam int SLOTS = 2 ** IDX_W;

  logic [7:0] tbl [SLOTS];

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    if (i < MSG_LEN) begin : g_char
      assign tbl[i] = MSG_TEXT[8*(MSG_LEN-1-i) +: 8];
    end else begin : g_pad
      assign tbl[i] = 8'h00;
    end
  end

  assign ch_o = tbl[idx_i];
endmodule

// File: rtl/sndr_ctrl.sv
module sndr_ctrl
  import sndr_pkg::*;
#(
  parameter int MSG_LEN = 16,
  parameter int IDX_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire_i,
  input  logic             settled_i,
  input  logic             start_i,
  input  logic             rdy_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             valid_o,
  output logic             busy_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(MSG_LEN - 1);

  sndr_state_t      state_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_SETTLE;
      idx_q   <= '0;
    end else begin
      case (state_q)
        ST_SETTLE: if (fire_i) begin
          state_q <= ST_SEND;
          idx_q   <= '0;
        end
        ST_SEND: if (rdy_i) begin
          if (idx_q == LAST_IDX) state_q <= ST_IDLE;
          else                   idx_q   <= idx_q + 1'b1;
        end
        ST_IDLE: if (start_i) begin
          state_q <= ST_SEND;
          idx_q   <= '0;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign idx_o   = idx_q;
  assign valid_o = (state_q == ST_SEND);
  assign busy_o  = (state_q != ST_IDLE);

  // R2: nothing is offered before the settle timer has expired
  a_r2_quiet_until_settled: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> settled_i);
  // R5: a stalled byte is held
  a_r5_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && !rdy_i |=> valid_o && $stable(idx_o));
  // R4: one position per transfer
  a_r4_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && rdy_i && (idx_o != LAST_IDX) |=> valid_o && (idx_o == $past(idx_o) + 1'b1));
  // R6: the last transfer ends the message
  a_r6_quiet_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && rdy_i && (idx_o == LAST_IDX) |=> !valid_o && !busy_o);
  // R7: a start pulse while idle restarts at position 0
  a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o && start_i |=> valid_o && (idx_o == '0));
endmodule

// File: rtl/msg_banner_tx.sv
module msg_banner_tx
  import sndr_pkg::*;
#(
  parameter int MSG_LEN    = 16,
  parameter int SETTLE_CYC = 50_000_000,
  parameter logic [8*MAX_CHARS-1:0] MSG_TEXT = "F23456789A123456"
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       txq_ready_i,
  output logic [7:0] txq_data_o,
  output logic       txq_valid_o,
  output logic       busy_o
);
  localparam int IDX_W = (MSG_LEN > 1) ? $clog2(MSG_LEN) : 1;

  logic             fire;
  logic             settled;
  logic [IDX_W-1:0] idx;

  sndr_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire_o (fire),
    .done_o (settled)
  );

  sndr_ctrl #(.MSG_LEN(MSG_LEN), .IDX_W(IDX_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire_i    (fire),
    .settled_i (settled),
    .start_i   (start_i),
    .rdy_i     (txq_ready_i),
    .idx_o     (idx),
    .valid_o   (txq_valid_o),
    .busy_o    (busy_o)
  );

  sndr_char_rom #(.MSG_LEN(MSG_LEN), .IDX_W(IDX_W), .MSG_TEXT(MSG_TEXT)) u_rom (
    .idx_i (idx),
    .ch_o  (txq_data_o)
  );

  // R10: busy stays high while a byte is offered
  a_r10_busy_covers_valid: assert property (@(posedge clk) disable iff (!rst_n)
    txq_valid_o |-> busy_o);
endmodule

// File: tb/msg_banner_tx_tb.sv
`timescale 1ns/1ps
module msg_banner_tx_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic rdy = 1'b1;
  logic       vld [3];
  logic [7:0] dat [3];
  logic       bsy [3];

  int n_chk = 0;
  int n_bad = 0;
  int cnt   [3];
  int first [3];

  string msgs   [3] = '{"123456789a12345", "f23456789a123456", "f23456789a1234567"};
  int    settle [3] = '{40, 25, 60};

  always #10 clk = ~clk;

  msg_banner_tx #(.MSG_LEN(15), .SETTLE_CYC(40), .MSG_TEXT("123456789a12345")) u_dut15 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .txq_ready_i(rdy),
    .txq_data_o(dat[0]), .txq_valid_o(vld[0]), .busy_o(bsy[0]));
  msg_banner_tx #(.MSG_LEN(16), .SETTLE_CYC(25), .MSG_TEXT("f23456789a123456")) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .txq_ready_i(rdy),
    .txq_data_o(dat[1]), .txq_valid_o(vld[1]), .busy_o(bsy[1]));
  msg_banner_tx #(.MSG_LEN(17), .SETTLE_CYC(60), .MSG_TEXT("f23456789a1234567")) u_dut17 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .txq_ready_i(rdy),
    .txq_data_o(dat[2]), .txq_valid_o(vld[2]), .busy_o(bsy[2]));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic ready_pat(input int p, input int c);
    case (p)
      0:       return 1'b1;
      1:       return (c % 3) == 0;
      default: return ((c * 7) % 11) < 4;
    endcase
  endfunction

  // pass p: start pulse at cycle 1 if restart, extra (ignored) pulse at ign_at
  task automatic run_pass(input int p, input int ncyc, input bit restart, input int ign_at);
    for (int c = 1; c <= ncyc; c++) begin
      @(negedge clk);
      rdy   = ready_pat(p, c);
      start = (restart && c == 1) || (c == ign_at);
      #1;
      for (int j = 0; j < 3; j++) begin
        chk("R10", int'(bsy[j]), int'(cnt[j] < msgs[j].len()));
        if (restart && c == 2) chk("R7", int'(vld[j]), 1);
        if (vld[j]) begin
          if (p == 0 && first[j] < 0) begin
            first[j] = c;
            chk("R2", c, settle[j]);
          end
          if (cnt[j] < msgs[j].len()) begin
            chk(cnt[j] == 0 ? "R3" : "R4", int'(dat[j]), int'(msgs[j][cnt[j]]));
            if (rdy) cnt[j]++;
          end else begin
            chk("R6", 1, 0);
          end
        end
      end
      if (restart && c == 1)
        for (int j = 0; j < 3; j++) cnt[j] = 0;
    end
    @(negedge clk);
    start = 1'b0;
    #1;
    for (int j = 0; j < 3; j++) begin
      chk(p == 1 ? "R8" : "R9", cnt[j], msgs[j].len());
      chk("R6", int'(vld[j]), 0);
      chk("R10", int'(bsy[j]), 0);
    end
  endtask

  initial begin
    for (int j = 0; j < 3; j++) begin
      cnt[j]   = 0;
      first[j] = -1;
    end
    repeat (3) @(negedge clk);
    #1;
    for (int j = 0; j < 3; j++) begin
      chk("R1", int'(vld[j]), 0);
      chk("R1", int'(bsy[j]), 1);
    end
    @(negedge clk);
    rst_n = 1'b1;
    run_pass(0, 300, 1'b0, 0);
    for (int j = 0; j < 3; j++) chk("R2", first[j], settle[j]);
    run_pass(1, 300, 1'b1, 10);
    run_pass(2, 300, 1'b1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule